// File: doc/BRIEF.md
# Load/Store Byte-Lane Steering Unit

This block sits between a 32-bit core's load/store path and a data memory port one word wide. Each request carries a byte address, a size code, a read/write flag and store data. One clock later the block presents a word-aligned address, a set of four byte enables and store data copied onto every lane. The memory keeps only the enabled bytes. Memory words are big-endian: enable bit 0 and lane 0 refer to the most significant byte of the word.

Read data comes back from memory in the cycle after the request. The block holds a record of which lanes the read asked for, picks the addressed byte or halfword out of the returned word, and pads it with zeros. An access whose address does not suit its size is never sent to memory. The block raises a one-cycle misalignment flag for it instead.

Top module: `byte_lane_steer`

## Requirements
- R1: When a request is accepted, memReq is high in the next cycle and memAddr equals the request address with its two low bits cleared.
- R2: Size codes are 00 byte, 01 halfword, 10 word. The low two address bits form a lane offset. A byte access sets only memBe bit [offset]. A halfword access at offset 0 sets bits 0 and 1 (value 4'b0011). A halfword access at offset 2 sets bits 2 and 3 (value 4'b1100). A word access sets 4'b1111. memBe bit 0 and lane 0 refer to data bits [31:24], and lane k refers to bits [31-8k:24-8k].
- R3: For a write, memWdata holds the low byte of reqWdata copied four times for a byte store, the low halfword copied twice for a halfword store, and reqWdata unchanged for a word store. memWe is high.
- R4: A halfword access with address bit 0 set, or a word access with either low address bit set, is misaligned. In the next cycle misalign is high for exactly one cycle, memReq is low and memBe is 4'b0000. No read result follows it.
- R5: One cycle after memReq is high for a read, rdValid is high. In that cycle rdData is the addressed byte, zero-extended, for a byte read. It is the addressed halfword, zero-extended, for a halfword read, and the whole memRdata for a word read.
- R6: When a new request is accepted in the same cycle that an earlier read's result is being extracted, the extraction still uses the earlier read's size and offset.
- R7: During reset memReq, memWe, memBe, misalign and rdValid are all zero.
- R8: Size code 11 behaves exactly like a word access, including the misalignment check.
- R9: When reqValid is low, the next cycle has memReq, memWe and misalign low and memBe equal to 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Access request present this cycle |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqSize | input | 2 | 00 byte, 01 halfword, 10 word, 11 word |
| reqAddr | input | ADDR_W | Byte address of the access |
| reqWdata | input | 32 | Store source value (low bits used for sub-word stores) |
| memRdata | input | 32 | Word returned by memory in the cycle after a read request |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Word-aligned memory address |
| memBe | output | 4 | Byte enables, bit 0 = most significant byte |
| memWdata | output | 32 | Lane-replicated store data |
| misalign | output | 1 | One-cycle misaligned-access flag |
| rdValid | output | 1 | rdData holds a load result |
| rdData | output | 32 | Extracted, zero-extended load result |

## Verification
Two functions can fall in the same cycle: issuing a new request and extracting the result of the read issued just before it. The bench drives requests every cycle, both as directed back-to-back reads with different sizes and offsets and as a long random stream in which most cycles carry a request. In every cycle where a result is due, it supplies a random memory word and compares rdData with the value computed from that earlier request's size and offset. Meanwhile it also checks the byte enables, address and data of the new request against its own model.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;
  localparam int DATA_W = 32;
  localparam int LANE_W = 8;
  localparam int HALF_W = 16;
  localparam int LANES  = DATA_W / LANE_W;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } accSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;    // capture address, store data and lane record of an accepted request
    logic captureRd;  // move the issued read's lane record to the extraction stage
  } steerStrb_t;
endpackage

// File: rtl/lane_steer_ctrl.sv
module lane_steer_ctrl
  import lane_steer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [1:0]       reqSize,
  input  logic [OFF_W-1:0] reqOff,
  output logic             memReq,
  output logic             memWe,
  output logic [LANES-1:0] memBe,
  output logic             misalign,
  output logic             rdValid,
  output steerStrb_t       strb
);
  accSize_e         sizeCode;
  logic             misNow;
  logic             accept;
  logic [LANES-1:0] beNow;
  logic [LANES-1:0] byteSel;

  assign sizeCode = accSize_e'(reqSize);

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      byteSel[i] = (reqOff == OFF_W'(i));
    end
  end

  always_comb begin
    unique case (sizeCode)
      SZ_BYTE: begin
        misNow = 1'b0;
        beNow  = byteSel;
      end
      SZ_HALF: begin
        misNow = reqOff[0];
        beNow  = reqOff[1] ? {2'b11, {(LANES-2){1'b0}}} : {{(LANES-2){1'b0}}, 2'b11};
      end
      default: begin
        misNow = (reqOff != '0);
        beNow  = '1;
      end
    endcase
  end

  assign accept         = reqValid && !misNow;
  assign strb.loadReq   = accept;
  assign strb.captureRd = memReq && !memWe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memReq   <= 1'b0;
      memWe    <= 1'b0;
      memBe    <= '0;
      misalign <= 1'b0;
      rdValid  <= 1'b0;
    end else begin
      memReq   <= accept;
      memWe    <= accept && reqWrite;
      memBe    <= accept ? beNow : '0;
      misalign <= reqValid && misNow;
      rdValid  <= memReq && !memWe;
    end
  end
endmodule

// File: rtl/lane_steer_datapath.sv
module lane_steer_datapath
  import lane_steer_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  steerStrb_t        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] rdData
);
  localparam int BYTE_COPIES = DATA_W / LANE_W;
  localparam int HALF_COPIES = DATA_W / HALF_W;

  accSize_e         issueSize, readSize;
  logic [OFF_W-1:0] issueOff,  readOff;
  logic [DATA_W-1:0] wdataRep;
  logic [LANE_W-1:0] laneByte [LANES];

  always_comb begin
    unique case (accSize_e'(reqSize))
      SZ_BYTE: wdataRep = {BYTE_COPIES{reqWdata[LANE_W-1:0]}};
      SZ_HALF: wdataRep = {HALF_COPIES{reqWdata[HALF_W-1:0]}};
      default: wdataRep = reqWdata;
    endcase
  end

  // issue stage: follows the request presented to memory
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr   <= '0;
      memWdata  <= '0;
      issueSize <= SZ_WORD;
      issueOff  <= '0;
    end else if (strb.loadReq) begin
      memAddr   <= {reqAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      memWdata  <= wdataRep;
      issueSize <= accSize_e'(reqSize);
      issueOff  <= reqAddr[OFF_W-1:0];
    end
  end

  // extraction stage: lane record of the read whose data is returning
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readSize <= SZ_WORD;
      readOff  <= '0;
    end else if (strb.captureRd) begin
      readSize <= issueSize;
      readOff  <= issueOff;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneByte[g] = memRdata[DATA_W-1-LANE_W*g -: LANE_W];
  end

  always_comb begin
    unique case (readSize)
      SZ_BYTE: rdData = {{(DATA_W-LANE_W){1'b0}}, laneByte[readOff]};
      SZ_HALF: rdData = readOff[1] ? {{(DATA_W-HALF_W){1'b0}}, memRdata[HALF_W-1:0]}
                                   : {{(DATA_W-HALF_W){1'b0}}, memRdata[DATA_W-1 -: HALF_W]};
      default: rdData = memRdata;
    endcase
  end
endmodule

// File: rtl/byte_lane_steer.sv
module byte_lane_steer
  import lane_steer_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  input  logic [31:0]       memRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [3:0]        memBe,
  output logic [31:0]       memWdata,
  output logic              misalign,
  output logic              rdValid,
  output logic [31:0]       rdData
);
  steerStrb_t strb;

  lane_steer_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqSize  (reqSize),
    .reqOff   (reqAddr[OFF_W-1:0]),
    .memReq   (memReq),
    .memWe    (memWe),
    .memBe    (memBe),
    .misalign (misalign),
    .rdValid  (rdValid),
    .strb     (strb)
  );

  lane_steer_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqSize  (reqSize),
    .reqWdata (reqWdata),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .rdData   (rdData)
  );
endmodule

// File: rtl/lane_steer_chk.sv
module lane_steer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       memReq,
  input logic       memWe,
  input logic [3:0] memBe,
  input logic       misalign,
  input logic       rdValid
);
  // R4: a flagged access never reaches memory
  a_r4_misalign_blocks: assert property (@(posedge clk) disable iff (!rstN)
    misalign |-> (!memReq && memBe == 4'b0000));

  // R5: every issued read is followed by a result cycle
  a_r5_read_followup: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |=> rdValid);

  // R5: a result cycle only follows an issued read
  a_r5_rdvalid_cause: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(memReq && !memWe));

  // R2: enables cover one, two or four lanes
  a_r2_lane_count: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> ($countones(memBe) == 1 || $countones(memBe) == 2 || $countones(memBe) == 4));

  // R9: no request, no memory activity
  a_r9_idle_req: assert property (@(posedge clk) disable iff (!rstN)
    !$past(reqValid) |-> (!memReq && !misalign));

  a_r9_idle_be: assert property (@(posedge clk) disable iff (!rstN)
    !memReq |-> (memBe == 4'b0000 && !memWe));
endmodule

bind byte_lane_steer lane_steer_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .memReq   (memReq),
  .memWe    (memWe),
  .memBe    (memBe),
  .misalign (misalign),
  .rdValid  (rdValid)
);

// File: tb/tb_byte_lane_steer.sv
`timescale 1ns/1ps
module tb_byte_lane_steer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0]  reqSize = 2'b00;
  logic [31:0] reqAddr = '0, reqWdata = '0, memRdata = '0;
  logic        memReq, memWe, misalign, rdValid;
  logic [31:0] memAddr, memWdata, rdData;
  logic [3:0]  memBe;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic        valid;
    logic        write;
    logic [1:0]  size;
    logic [31:0] addr;
    logic [31:0] wdata;
  } req_t;

  req_t p1, p2;

  always #10 clk = ~clk;

  byte_lane_steer dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata), .memRdata(memRdata),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memBe(memBe),
    .memWdata(memWdata), .misalign(misalign), .rdValid(rdValid), .rdData(rdData)
  );

  function automatic logic isMis(req_t r);
    case (r.size)
      2'b00:   return 1'b0;
      2'b01:   return r.addr[0];
      default: return r.addr[1:0] != 2'b00;
    endcase
  endfunction

  function automatic logic [3:0] expBe(req_t r);
    case (r.size)
      2'b00:   return 4'b0001 << r.addr[1:0];
      2'b01:   return (r.addr[1:0] == 2'b10) ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] expWdata(req_t r);
    case (r.size)
      2'b00:   return {r.wdata[7:0], r.wdata[7:0], r.wdata[7:0], r.wdata[7:0]};
      2'b01:   return {r.wdata[15:0], r.wdata[15:0]};
      default: return r.wdata;
    endcase
  endfunction

  function automatic logic [31:0] expRead(req_t r, logic [31:0] w);
    int sh;
    case (r.size)
      2'b00: begin
        sh = 24 - 8 * int'(r.addr[1:0]);
        return (w >> sh) & 32'h0000_00FF;
      end
      2'b01:   return r.addr[1] ? (w & 32'h0000_FFFF) : (w >> 16);
      default: return w;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // check outputs after the edge, then drive the next request
  task automatic step(req_t n);
    logic acc1, acc2;
    @(negedge clk);
    acc1 = p1.valid && !isMis(p1);
    acc2 = p2.valid && !isMis(p2) && !p2.write;
    check("R1/R9 memReq", 32'(memReq), 32'(acc1));
    check("R4 misalign", 32'(misalign), 32'(p1.valid && isMis(p1)));
    check("R2/R4/R8 memBe", 32'(memBe), acc1 ? 32'(expBe(p1)) : 32'h0);
    check("R3/R9 memWe", 32'(memWe), 32'(acc1 && p1.write));
    if (acc1) check("R1 memAddr", memAddr, {p1.addr[31:2], 2'b00});
    if (acc1 && p1.write) check("R3 memWdata", memWdata, expWdata(p1));
    check("R5 rdValid", 32'(rdValid), 32'(acc2));
    if (acc2) begin
      memRdata = $urandom;
      #1;
      check("R5/R6 rdData", rdData, expRead(p2, memRdata));
    end
    reqValid = n.valid; reqWrite = n.write; reqSize = n.size;
    reqAddr = n.addr; reqWdata = n.wdata;
    p2 = p1;
    p1 = n;
  endtask

  function automatic req_t mk(logic v, logic w, logic [1:0] s, logic [31:0] a);
    req_t r;
    r.valid = v; r.write = w; r.size = s; r.addr = a; r.wdata = $urandom;
    return r;
  endfunction

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    p1 = mk(0, 0, 0, 0);
    p2 = p1;
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 memReq", 32'(memReq), 0);
    check("R7 memWe", 32'(memWe), 0);
    check("R7 memBe", 32'(memBe), 0);
    check("R7 misalign", 32'(misalign), 0);
    check("R7 rdValid", 32'(rdValid), 0);
    rstN = 1'b1;
    // directed sweep: every size code, offset and direction (R2, R3, R4, R8)
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 4; o++)
        for (int w = 0; w < 2; w++) begin
          step(mk(1, w[0], s[1:0], {28'h1234_567, 2'b00, o[1:0]}));
          step(mk(0, 0, 0, 0));
          step(mk(0, 0, 0, 0));
        end
    // R6: back-to-back reads with different lanes
    step(mk(1, 0, 2'b00, 32'h0000_0103));
    step(mk(1, 0, 2'b01, 32'h0000_0200));
    step(mk(1, 0, 2'b01, 32'h0000_0302));
    step(mk(1, 0, 2'b10, 32'h0000_0400));
    step(mk(1, 0, 2'b00, 32'h0000_0501));
    step(mk(1, 1, 2'b00, 32'h0000_0602));
    step(mk(1, 0, 2'b01, 32'h0000_0701));
    step(mk(0, 0, 0, 0));
    step(mk(0, 0, 0, 0));
    // random stream
    for (int i = 0; i < 3000; i++) begin
      step(mk(($urandom % 10) != 0, $urandom % 2, 2'($urandom % 4), $urandom));
    end
    step(mk(0, 0, 0, 0));
    step(mk(0, 0, 0, 0));
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule